// File: doc/BRIEF.md
# RAW10 Pixel Packer and Lane Distributor

This block accepts 10-bit raw sensor pixels one at a time and turns them into a dense byte stream. Each run of four pixels produces five bytes. The first four bytes are the upper eight bits of each pixel, in the order the pixels arrived. The fifth byte collects the two low bits of all four pixels. The byte stream is then dealt round-robin onto 1, 2 or 4 byte lanes of a 32-bit output word. Five-byte groups are not aligned to lane boundaries, so a group that starts part way through a beat continues in the next one.

Pixels enter through a valid/ready port. A last-pixel flag marks the end of a line. Lane words leave through a valid/ready port that carries a per-lane byte enable. The lane count is a static configuration input. It may only change while the block is idle between lines.

Top module: `raw10_lane_packer`

## Requirements
- R1: Within a group of four pixels, the first four bytes emitted are bits 9:2 of the first, second, third and fourth pixel, in that order.
- R2: The fifth byte of a group holds the two low bits of each pixel in the group. The first pixel's bits sit at 1:0, the second at 3:2, the third at 5:4 and the fourth at 7:6.
- R3: `lane_sel` picks the lane count: 00 gives one lane, 01 two lanes, 10 four lanes. The code 11 also gives four lanes.
- R4: Bytes are assigned to lanes in stream order, filling lane 0 upward in each beat. Groups continue across beats without realigning to lane 0.
- R5: Lane k occupies `out_data[8k+7:8k]`. In every beat the enabled lanes are a contiguous run starting at lane 0, no longer than the lane count. Disabled lanes carry zero data.
- R6: When a pixel with `in_last` set is accepted, three things happen. If the group is incomplete, its low-bits byte is emitted with zeros in the slots of the missing pixels. Any partial beat is flushed with only its filled lanes enabled. The next pixel starts a new group at lane 0.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_be` hold steady. No byte is lost or duplicated under any pattern of backpressure.
- R8: `in_ready` is low whenever a held output word has not yet been taken.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_sel | input | 2 | Lane count select (00=1, 01=2, 10/11=4) |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Pixel accepted when high together with in_valid |
| in_pixel | input | 10 | Raw 10-bit pixel |
| in_last | input | 1 | Marks the last pixel of a line |
| out_valid | output | 1 | Lane word valid |
| out_ready | input | 1 | Downstream accepts the lane word |
| out_data | output | 32 | Lane word, lane 0 in the low byte |
| out_be | output | 4 | Per-lane byte enable |

## Verification
A wrong group index moves the low-bits byte to the wrong place, or scrambles its bit slots, within five bytes of the fault. A lane-fill counter that drifts shifts every later byte of the line to a neighbouring lane, so the very next beat mismatches the scoreboard. Flush faults show up on the final beat of a line as a wrong byte-enable pattern, or as stale data leaking into the first beat of the next line. Backpressure faults surface as a missing or repeated word the moment the stall is released.

// File: rtl/raw10_pkg.sv
package raw10_pkg;

  typedef enum logic [1:0] {
    LANES_ONE  = 2'b00,
    LANES_TWO  = 2'b01,
    LANES_FOUR = 2'b10,
    LANES_ALT4 = 2'b11
  } lane_mode_e;

  function automatic int lanes_of(lane_mode_e m);
    case (m)
      LANES_ONE: return 1;
      LANES_TWO: return 2;
      default:   return 4;
    endcase
  endfunction

endpackage

// File: rtl/raw10_group_splitter.sv
module raw10_group_splitter #(
  parameter int PIX_W  = 10,
  parameter int BYTE_W = 8,
  parameter int GROUP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [PIX_W-1:0]  pix,
  input  logic              last,
  output logic [BYTE_W-1:0] up_byte,
  output logic [BYTE_W-1:0] low_byte,
  output logic              two_bytes
);
  localparam int LOW_W = PIX_W - BYTE_W;
  localparam int IDX_W = $clog2(GROUP);

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] low_q;
  logic [BYTE_W-1:0] low_ext;

  assign up_byte   = pix[PIX_W-1 -: BYTE_W];
  assign low_ext   = BYTE_W'(pix[LOW_W-1:0]);
  assign low_byte  = low_q | (low_ext << (LOW_W * int'(idx_q)));
  assign two_bytes = (int'(idx_q) == GROUP - 1) || last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      low_q <= '0;
    end else if (take) begin
      if (two_bytes) begin
        idx_q <= '0;
        low_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
        low_q <= low_byte;
      end
    end
  end

  // R6
  group_restart_chk: assert property (@(posedge clk) disable iff (rst)
    take && last |=> idx_q == '0 && low_q == '0);

endmodule

// File: rtl/raw10_lane_accum.sv
module raw10_lane_accum #(
  parameter int BYTE_W    = 8,
  parameter int MAX_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(MAX_LANES+2)-1:0] nl,
  input  logic                        take,
  input  logic [BYTE_W-1:0]           b0,
  input  logic [BYTE_W-1:0]           b1,
  input  logic                        two,
  input  logic                        last,
  output logic                        room,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [BYTE_W*MAX_LANES-1:0] out_data,
  output logic [MAX_LANES-1:0]        out_be
);
  localparam int CNT_W  = $clog2(MAX_LANES + 2);
  localparam int DATA_W = BYTE_W * MAX_LANES;
  localparam int SLOTS  = MAX_LANES + 1;

  logic [BYTE_W-1:0] acc_q [SLOTS];
  logic [BYTE_W-1:0] comb  [SLOTS];
  logic [CNT_W-1:0]  fill_q, total;
  logic              flush_q, drain, slot_free;

  function automatic logic [DATA_W+MAX_LANES-1:0] make_beat(
      input logic [BYTE_W-1:0] arr [SLOTS], input int cnt);
    logic [DATA_W-1:0]    d;
    logic [MAX_LANES-1:0] e;
    d = '0;
    e = '0;
    for (int k = 0; k < MAX_LANES; k++) begin
      if (k < cnt) begin
        d[k*BYTE_W +: BYTE_W] = arr[k];
        e[k] = 1'b1;
      end
    end
    return {d, e};
  endfunction

  assign total     = fill_q + (two ? CNT_W'(2) : CNT_W'(1));
  assign drain     = (fill_q != '0) && ((fill_q >= nl) || flush_q);
  assign slot_free = !out_valid || out_ready;
  assign room      = slot_free && !drain;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      if (i < int'(fill_q))       comb[i] = acc_q[i];
      else if (i == int'(fill_q)) comb[i] = b0;
      else if (i == int'(fill_q) + 1) comb[i] = two ? b1 : '0;
      else                        comb[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
      fill_q    <= '0;
      flush_q   <= 1'b0;
      for (int i = 0; i < SLOTS; i++) acc_q[i] <= '0;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (slot_free && drain) begin
        {out_data, out_be} <= make_beat(acc_q, int'(fill_q));
        out_valid <= 1'b1;
        fill_q    <= '0;
        flush_q   <= 1'b0;
      end else if (take) begin
        if (total >= nl) begin
          {out_data, out_be} <= make_beat(comb, int'(nl));
          out_valid <= 1'b1;
          acc_q[0]  <= comb[nl];
          fill_q    <= total - nl;
          flush_q   <= last && (total != nl);
        end else if (last) begin
          {out_data, out_be} <= make_beat(comb, int'(total));
          out_valid <= 1'b1;
          fill_q    <= '0;
        end else begin
          for (int i = 0; i < SLOTS; i++) acc_q[i] <= comb[i];
          fill_q <= total;
        end
      end
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be));

  // R5
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_be != '0 && ((out_be & (out_be + 1'b1)) == '0)
                  && $countones(out_be) <= int'(nl));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !room);

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_q <= nl);

endmodule

// File: rtl/raw10_lane_packer.sv
module raw10_lane_packer #(
  parameter int PIX_W     = 10,
  parameter int BYTE_W    = 8,
  parameter int MAX_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  lane_sel,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [PIX_W-1:0]            in_pixel,
  input  logic                        in_last,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [BYTE_W*MAX_LANES-1:0] out_data,
  output logic [MAX_LANES-1:0]        out_be
);
  localparam int CNT_W = $clog2(MAX_LANES + 2);

  logic [CNT_W-1:0]  nl;
  logic              take, two;
  logic [BYTE_W-1:0] up_b, low_b;

  assign nl   = CNT_W'(raw10_pkg::lanes_of(raw10_pkg::lane_mode_e'(lane_sel)));
  assign take = in_valid && in_ready;

  raw10_group_splitter #(.PIX_W(PIX_W), .BYTE_W(BYTE_W), .GROUP(4)) u_split (
    .clk(clk), .rst(rst), .take(take), .pix(in_pixel), .last(in_last),
    .up_byte(up_b), .low_byte(low_b), .two_bytes(two)
  );

  raw10_lane_accum #(.BYTE_W(BYTE_W), .MAX_LANES(MAX_LANES)) u_accum (
    .clk(clk), .rst(rst), .nl(nl), .take(take), .b0(up_b), .b1(low_b),
    .two(two), .last(in_last), .room(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_be(out_be)
  );

endmodule

// File: tb/tb_raw10_lane_packer.sv
module tb_raw10_lane_packer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [1:0] lane_sel = 2'b00;
  logic in_valid = 0, in_last = 0, out_ready = 1;
  logic [9:0] in_pixel = '0;
  logic in_ready, out_valid;
  logic [31:0] out_data;
  logic [3:0] out_be;

  typedef struct packed { logic [31:0] d; logic [3:0] be; } beat_t;
  beat_t exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0;
  bit stall = 0, hold = 0;

  raw10_lane_packer dut (
    .clk(clk), .rst(rst), .lane_sel(lane_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_pixel(in_pixel), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_be(out_be)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    out_ready = hold ? 1'b0 : (stall ? (($urandom % 4) != 0) : 1'b1);

  // monitor: compare each accepted word against the scoreboard
  always @(negedge clk) begin
    #1;
    if (!rst && out_valid && out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7 unexpected word actual=%h/%b expected=none", out_data, out_be);
      end else begin
        beat_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_data !== e.d || out_be !== e.be) begin
          n_bad++;
          $display("FAIL %s actual=%h/%b expected=%h/%b", t, out_data, out_be, e.d, e.be);
        end
      end
    end
  end

  function automatic int lanes_for(logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
  endfunction

  // reference packing model (R1, R2, R4, R5, R6) plus pixel driver
  task automatic send_line(int n, logic [1:0] mode, string tag, int seed);
    logic [7:0] bq[$];
    logic [7:0] low;
    logic [9:0] px[];
    int nl;
    nl = lanes_for(mode);
    px = new[n];
    low = '0;
    for (int i = 0; i < n; i++) begin
      px[i] = 10'((i * 37 + seed * 91 + 5 + i * i * 13) & 10'h3FF);
      bq.push_back(px[i][9:2]);
      low = low | (8'(px[i][1:0]) << (2 * (i % 4)));
      if ((i % 4) == 3 || i == n - 1) begin
        bq.push_back(low);
        low = '0;
      end
    end
    for (int k = 0; k < bq.size(); k += nl) begin
      beat_t b;
      b = '0;
      for (int j = 0; j < nl; j++)
        if (k + j < bq.size()) begin
          b.d[8*j +: 8] = bq[k + j];
          b.be[j] = 1'b1;
        end
      exp_q.push_back(b);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < n; i++) begin
      in_pixel = px[i];
      in_last  = (i == n - 1);
      in_valid = 1'b1;
      forever begin
        #1;
        if (in_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic line_in_mode(int n, logic [1:0] mode, string tag, int seed);
    wait_idle();
    lane_sel = mode;
    @(negedge clk);
    send_line(n, mode, tag, seed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R7 actual=hung expected=complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #2;
    // R9 reset state
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 actual=%b/%b expected=0/1", out_valid, in_ready);
    end
    @(negedge clk);
    line_in_mode(4, 2'b00, "R1", 1);
    line_in_mode(4, 2'b10, "R2", 2);
    line_in_mode(10, 2'b01, "R4", 3);
    line_in_mode(12, 2'b10, "R4", 4);
    line_in_mode(8, 2'b00, "R4", 5);
    line_in_mode(5, 2'b01, "R5", 6);
    line_in_mode(9, 2'b00, "R6", 7);
    line_in_mode(7, 2'b10, "R6", 8);
    line_in_mode(6, 2'b10, "R6", 9);
    line_in_mode(1, 2'b01, "R6", 10);
    line_in_mode(3, 2'b01, "R6", 11);
    send_line(5, 2'b01, "R6", 12);
    line_in_mode(10, 2'b11, "R3", 13);
    wait_idle();
    stall = 1;
    line_in_mode(13, 2'b00, "R7", 14);
    line_in_mode(13, 2'b01, "R7", 15);
    line_in_mode(13, 2'b10, "R7", 16);
    line_in_mode(11, 2'b10, "R7", 17);
    wait_idle();
    stall = 0;
    lane_sel = 2'b10;
    @(negedge clk);
    hold = 1;
    @(negedge clk);
    fork
      send_line(8, 2'b10, "R7", 18);
      begin
        repeat (6) @(negedge clk);
        #2;
        // R8 held word blocks input
        n_chk++;
        if (out_valid !== 1'b1 || in_ready !== 1'b0) begin
          n_bad++;
          $display("FAIL R8 actual=%b/%b expected=1/0", out_valid, in_ready);
        end
        hold = 0;
      end
    join
    wait_idle();
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R7 actual=%0d left expected=0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule